// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block

This block is a configurable two-level logic plane. It takes 36 input signals and computes 16 combinational sum outputs, one per macrocell slot, plus six control-term outputs. Each sum output is the OR of two sources: five product terms that belong only to that output and pass through a fixed OR, and any chosen subset of a pool of 32 shared product terms, picked by a per-output selection mask. A pool term can feed many outputs at once, so logic that several outputs need is computed only once. Each control term works like a product term, but it can be switched to OR its selected literals instead of ANDing them.

The configuration is a bank of 134 words, each 73 bits wide. Software writes the bank through a word-wide write port while `rst_n` is held low. The outputs read zero during that time. Once `rst_n` is released, the bank is frozen and the outputs follow `in_sig` combinationally. Each term word has a true-literal enable field in bits [35:0] and a complement-literal enable field in bits [71:36]. Bit 72 of a control-term word selects its mode.

Word addresses, with o the output index, k the dedicated term index, p the pool index and c the control index:

| Words | Address |
|---|---|
| Dedicated term k of output o | o*5+k (0..79) |
| Pool term p | 80+p |
| OR selection mask of output o | 112+o, bits [31:0]; bit p selects pool term p |
| Control term c | 128+c |

Top module: `sop_logic_block`

## Requirements
- R1: While `rst_n` is low, `mc_sum` and `ctl_term` are all zero, whatever `in_sig` holds.
- R2: A configuration write is stored only when `cfg_we` is high and `rst_n` is low at a rising clock edge. A write issued while `rst_n` is high leaves the configuration, and therefore every output, unchanged.
- R3: A product term is the AND of its enabled literals. Bit j of the true field (bit j of the word) enables `in_sig[j]`. Bit j of the complement field (bit 36+j of the word) enables `~in_sig[j]`. A term that enables both forms of one input is always 0.
- R4: A product term with no literal enabled evaluates to 0. An output whose five dedicated terms are empty and whose mask is zero stays 0.
- R5: `mc_sum[o]` is 1 whenever any of its five dedicated terms, at words o*5+k, is 1.
- R6: Pool term p is stored at word 80+p. Bit p of the mask at word 112+o routes it to `mc_sum[o]`. A pool term that is not selected has no effect on that output.
- R7: A single pool term selected in several masks drives every one of those outputs.
- R8: One output can combine all 37 of its terms (5 dedicated plus all 32 pool terms). Any single one of them being true raises the output.
- R9: Control term c is stored at word 128+c. With bit 72 clear it is a product term, following R3 and R4. With bit 72 set it is the OR of its enabled literals, and it is 0 when no literal is enabled.
- R10: Once configured and out of reset, both outputs follow a change on `in_sig` within the same clock cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Low: program mode with outputs zeroed; high: run mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 73 | Configuration word |
| in_sig | input | 36 | Logic inputs |
| mc_sum | output | 16 | Per-macrocell sum-of-products outputs |
| ctl_term | output | 6 | Control-term outputs |

## Verification
The bench builds the block with its default sizes: 36 inputs, 16 outputs, 5 dedicated terms each, a 32-term pool and 6 control terms. At these sizes one output can be wired to all 37 term sources, and every one of them can be lit in turn by a single-hot input. Directed configurations cover a pool term shared by three outputs, the top pool index, contradictory literals, empty terms, and both control-term modes. Several random sparse configurations are then compared vector by vector against a software model of the same word bank.

// File: rtl/sop_pkg.sv
package sop_pkg;
    // Control-term operating mode, held in the top bit of a control word.
    typedef enum logic {
        CT_PRODUCT = 1'b0,
        CT_SUM     = 1'b1
    } ct_mode_e;

    localparam int DEF_N_IN   = 36;
    localparam int DEF_N_OUT  = 16;
    localparam int DEF_N_DED  = 5;
    localparam int DEF_N_POOL = 32;
    localparam int DEF_N_CT   = 6;
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
    parameter int DEPTH = 134,
    parameter int W     = 73,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  word [DEPTH]
);
    typedef struct {
        logic [W-1:0] mem [DEPTH];
    } store_t;

    store_t st_d;
    store_t st_q;

    // Writes land only in program mode (reset held low).
    always_comb begin
        st_d = st_q;
        if (!rst_n && we && (int'(addr) < DEPTH)) begin
            st_d.mem[addr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_out
        assign word[i] = st_q.mem[i];
        // Configuration is frozen once the previous edge saw run mode.
        assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> $stable(st_q.mem[i]));
    end
endmodule

// File: rtl/sop_term.sv
module sop_term #(
    parameter int N_IN = 36
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] t_mask,
    input  logic [N_IN-1:0] c_mask,
    input  logic            sum_mode,
    input  logic [N_IN-1:0] x,
    output logic            y
);
    logic any_lit;
    logic prod_val;
    logic sum_val;

    assign any_lit  = |{t_mask, c_mask};
    assign prod_val = any_lit & (&(~t_mask | x)) & (&(~c_mask | ~x));
    assign sum_val  = |((t_mask & x) | (c_mask & ~x));
    assign y        = sum_mode ? sum_val : prod_val;

    assert_empty_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_mask == '0 && c_mask == '0) |-> !y);
    assert_contradiction_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sum_mode && (|(t_mask & c_mask))) |-> !y);
    assert_sum_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_mode && (|(t_mask & x))) |-> y);
endmodule

// File: rtl/sop_logic_block.sv
module sop_logic_block
    import sop_pkg::*;
#(
    parameter int N_IN   = DEF_N_IN,
    parameter int N_OUT  = DEF_N_OUT,
    parameter int N_DED  = DEF_N_DED,
    parameter int N_POOL = DEF_N_POOL,
    parameter int N_CT   = DEF_N_CT,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [2*N_IN:0]   cfg_wdata,
    input  logic [N_IN-1:0]   in_sig,
    output logic [N_OUT-1:0]  mc_sum,
    output logic [N_CT-1:0]   ctl_term
);
    localparam int TW        = 2 * N_IN;
    localparam int W         = TW + 1;
    localparam int N_DED_T   = N_OUT * N_DED;
    localparam int BASE_POOL = N_DED_T;
    localparam int BASE_OR   = BASE_POOL + N_POOL;
    localparam int BASE_CT   = BASE_OR + N_OUT;
    localparam int DEPTH     = BASE_CT + N_CT;

    logic [W-1:0]       cfg_word [DEPTH];
    logic [N_DED_T-1:0] ded_y;
    logic [N_POOL-1:0]  pool_y;
    logic [N_OUT-1:0]   raw_sum;
    logic [N_CT-1:0]    ct_raw;

    sop_cfg_store #(.DEPTH(DEPTH), .W(W), .AW(ADDR_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .word  (cfg_word)
    );

    // Dedicated terms: fixed OR per output.
    for (genvar i = 0; i < N_DED_T; i++) begin : g_ded
        sop_term #(.N_IN(N_IN)) u_t (
            .clk      (clk),
            .rst_n    (rst_n),
            .t_mask   (cfg_word[i][N_IN-1:0]),
            .c_mask   (cfg_word[i][TW-1:N_IN]),
            .sum_mode (1'b0),
            .x        (in_sig),
            .y        (ded_y[i])
        );
    end

    // Shared pool terms.
    for (genvar p = 0; p < N_POOL; p++) begin : g_pool
        sop_term #(.N_IN(N_IN)) u_t (
            .clk      (clk),
            .rst_n    (rst_n),
            .t_mask   (cfg_word[BASE_POOL+p][N_IN-1:0]),
            .c_mask   (cfg_word[BASE_POOL+p][TW-1:N_IN]),
            .sum_mode (1'b0),
            .x        (in_sig),
            .y        (pool_y[p])
        );
    end

    // Control terms with selectable AND / OR behaviour.
    for (genvar c = 0; c < N_CT; c++) begin : g_ct
        sop_term #(.N_IN(N_IN)) u_t (
            .clk      (clk),
            .rst_n    (rst_n),
            .t_mask   (cfg_word[BASE_CT+c][N_IN-1:0]),
            .c_mask   (cfg_word[BASE_CT+c][TW-1:N_IN]),
            .sum_mode (cfg_word[BASE_CT+c][TW] == CT_SUM),
            .x        (in_sig),
            .y        (ct_raw[c])
        );
    end

    // Output OR plane: fixed part plus programmable selection of the pool.
    for (genvar o = 0; o < N_OUT; o++) begin : g_or
        logic ded_any;
        logic pool_any;
        assign ded_any    = |ded_y[o*N_DED +: N_DED];
        assign pool_any   = |(pool_y & cfg_word[BASE_OR+o][N_POOL-1:0]);
        assign raw_sum[o] = ded_any | pool_any;

        assert_ded_reach_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ded_any |-> mc_sum[o]);
        assert_pool_reach_R6: assert property (@(posedge clk) disable iff (!rst_n)
            pool_any |-> mc_sum[o]);
    end

    assign mc_sum   = rst_n ? raw_sum : '0;
    assign ctl_term = rst_n ? ct_raw  : '0;

    // Mode bits of plain terms and upper bits of mask words carry no function.
    logic unused_cfg;
    always_comb begin
        unused_cfg = 1'b0;
        for (int i = 0; i < BASE_OR; i++) begin
            unused_cfg = unused_cfg ^ cfg_word[i][TW];
        end
        for (int o = 0; o < N_OUT; o++) begin
            unused_cfg = unused_cfg ^ (^cfg_word[BASE_OR+o][W-1:N_POOL]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_quiet_in_reset_R1: assert (mc_sum == '0 && ctl_term == '0);
        end
    end
endmodule

// File: tb/sim_sop_logic_block.sv
`timescale 1ns/1ps
module sim_sop_logic_block;
    localparam int NI = 36, NO = 16, ND = 5, NP = 32, NC = 6;
    localparam int TW = 2*NI, W = TW+1;
    localparam int BP = NO*ND, BO = BP+NP, BC = BO+NO, DEPTH = BC+NC;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [W-1:0]  cfg_wdata = '0;
    logic [NI-1:0] in_sig = '0;
    logic [NO-1:0] mc_sum;
    logic [NC-1:0] ctl_term;

    logic [W-1:0] shadow [DEPTH];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    sop_logic_block u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_sig(in_sig), .mc_sum(mc_sum), .ctl_term(ctl_term)
    );

    function automatic logic [W-1:0] mk(logic [NI-1:0] t, logic [NI-1:0] c, logic m);
        return {m, c, t};
    endfunction

    function automatic logic f_pt(logic [W-1:0] w, logic [NI-1:0] x);
        logic [NI-1:0] t = w[NI-1:0];
        logic [NI-1:0] c = w[TW-1:NI];
        if (t == '0 && c == '0) return 1'b0;
        return ((x & t) == t) && ((~x & c) == c);
    endfunction

    function automatic logic f_ct(logic [W-1:0] w, logic [NI-1:0] x);
        if (w[TW]) return |((x & w[NI-1:0]) | (~x & w[TW-1:NI]));
        return f_pt(w, x);
    endfunction

    function automatic logic [NO-1:0] exp_mc(logic [NI-1:0] x);
        logic [NO-1:0] r = '0;
        for (int o = 0; o < NO; o++) begin
            for (int k = 0; k < ND; k++) r[o] |= f_pt(shadow[o*ND+k], x);
            for (int p = 0; p < NP; p++)
                if (shadow[BO+o][p]) r[o] |= f_pt(shadow[BP+p], x);
        end
        return r;
    endfunction

    function automatic logic [NC-1:0] exp_ct(logic [NI-1:0] x);
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++) r[c] = f_ct(shadow[BC+c], x);
        return r;
    endfunction

    function automatic logic [W-1:0] rnd_term(logic allow_mode);
        logic [W-1:0] w = '0;
        if ($urandom_range(0, 7) != 0) begin
            for (int n = 0; n < int'($urandom_range(1, 3)); n++) begin
                int j = int'($urandom_range(0, NI-1));
                if ($urandom_range(0, 1) != 0) w[j] = 1'b1;
                else w[NI+j] = 1'b1;
            end
        end
        if (allow_mode) w[TW] = $urandom_range(0, 1) != 0;
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; write captured at the next rising edge.
    task automatic wr(int a, logic [W-1:0] d);
        cfg_addr = 8'(a);
        cfg_wdata = d;
        cfg_we = 1'b1;
        if (!rst_n && a < DEPTH) shadow[a] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int a = 0; a < DEPTH; a++) wr(a, '0);
    endtask

    // Apply inputs, then compare the full outputs in the same cycle (R10 path).
    task automatic apply_full(string tag, logic [NI-1:0] x);
        in_sig = x;
        #1;
        chk(tag, 32'(mc_sum), 32'(exp_mc(x)));
        chk(tag, 32'(ctl_term), 32'(exp_ct(x)));
    endtask

    function automatic logic [NI-1:0] oh(int j);
        return NI'(1) << j;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state with varied inputs
        in_sig = '1; #1;
        chk("R1 reset mc", 32'(mc_sum), 0);
        chk("R1 reset ct", 32'(ctl_term), 0);
        @(negedge clk);

        // Directed configuration
        clear_all();
        wr(0*ND+0, mk(oh(0), oh(1), 1'b0));        // out0: in0 & ~in1
        wr(0*ND+2, mk(oh(9), '0, 1'b0));            // out0: in9
        for (int p = 0; p < NP; p++) wr(BP+p, mk(oh(p), '0, 1'b0));
        for (int o = 2; o <= 4; o++) wr(BO+o, 32'h4); // shared pool2
        wr(BO+5, {W{1'b1}});                        // all pool terms
        for (int k = 0; k < 4; k++) wr(5*ND+k, mk(oh(32+k), '0, 1'b0));
        wr(5*ND+4, mk(oh(32) | oh(33), '0, 1'b0));
        wr(BO+6, W'(32'h8000_0000));                // pool31 only
        wr(BC+0, mk(oh(3) | oh(4), '0, 1'b0));      // product
        wr(BC+1, mk(oh(3) | oh(4), '0, 1'b1));      // sum
        wr(BC+2, mk('0, '0, 1'b1));                 // empty sum
        wr(BC+3, mk(oh(5), oh(5), 1'b0));           // contradiction
        wr(BC+4, mk(oh(6), oh(7), 1'b1));           // in6 | ~in7
        in_sig = 36'h5_A5A5_A5A5; #1;
        chk("R1 reset after program", 32'(mc_sum), 0);
        @(negedge clk);
        rst_n = 1'b1;

        apply_full("R3 true literal", oh(0));
        chk("R3 out0 true", 32'(mc_sum[0]), 1);
        apply_full("R3 complement literal", oh(0) | oh(1));
        chk("R3 out0 blocked", 32'(mc_sum[0]), 0);
        apply_full("R4 all ones", '1);
        chk("R4 empty out1 high inputs", 32'(mc_sum[1]), 0);
        apply_full("R4 all zeros", '0);
        chk("R4 empty out1 low inputs", 32'(mc_sum[1]), 0);
        chk("R9 empty sum ct2", 32'(ctl_term[2]), 0);
        apply_full("R5 dedicated term 2", oh(9));
        chk("R5 out0 from ded2", 32'(mc_sum[0]), 1);
        apply_full("R7 shared pool", oh(2));
        chk("R7 out2..4", 32'(mc_sum[4:2]), 32'h7);
        apply_full("R6 pool31", oh(31));
        chk("R6 out6 selected", 32'(mc_sum[6]), 1);
        chk("R6 out2 unselected", 32'(mc_sum[2]), 0);
        for (int j = 0; j < NI; j++) begin
            in_sig = oh(j); #1;
            chk($sformatf("R8 out5 source %0d", j), 32'(mc_sum[5]), 1);
        end
        in_sig = oh(32) | oh(33); #1;
        chk("R8 out5 ded4", 32'(mc_sum[5]), 1);
        apply_full("R9 modes", oh(3) | oh(7));
        chk("R9 product/sum ct1..0", 32'(ctl_term[1:0]), 32'h2);
        apply_full("R9 both", oh(3) | oh(4) | oh(5));
        chk("R9 product ct0 and ct3 contradiction", 32'(ctl_term[3:0]), 32'h3);
        chk("R9 sum with complement ct4", 32'(ctl_term[4]), 1);
        @(negedge clk);
        // R10: two input changes inside one clock cycle
        apply_full("R10 first", oh(0));
        apply_full("R10 second", oh(1));
        chk("R10 out0 dropped", 32'(mc_sum[0]), 0);
        @(negedge clk);
        // R2: write in run mode is ignored
        wr(0, mk(oh(7), '0, 1'b0));
        @(negedge clk);
        apply_full("R2 ignored write", oh(7));
        chk("R2 out0 unchanged", 32'(mc_sum[0]), 0);
        @(negedge clk);

        // Random sparse configurations
        for (int cfg = 0; cfg < 5; cfg++) begin
            rst_n = 1'b0;
            @(negedge clk);
            for (int a = 0; a < BO; a++) wr(a, rnd_term(1'b0));
            for (int o = 0; o < NO; o++) wr(BO+o, W'($urandom & $urandom));
            for (int c = 0; c < NC; c++) wr(BC+c, rnd_term(1'b1));
            in_sig = {$urandom_range(0, 15), $urandom}; #1;
            chk("R1 random reset", 32'(mc_sum), 0);
            @(negedge clk);
            rst_n = 1'b1;
            for (int v = 0; v < 60; v++) begin
                logic [NI-1:0] x = {4'($urandom), 32'($urandom)};
                if (v % 3 == 0) x = x & {4'($urandom), 32'($urandom)};
                apply_full("R3 R5 R6 R9 random", x);
                @(negedge clk);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        $urandom(32'd20240611);
    end
endmodule